// File: doc/BRIEF.md
# DDR SDRAM Command Decoder

This block watches the command pins of a DDR SDRAM rank (chip select, row strobe, column strobe, write enable, clock enable, the A10 address bit and the two bank address bits) on each rising clock edge. One cycle later it presents the decoded command as a one-hot vector, together with the addressed bank as a one-hot vector in bank-letter order, an all-banks flag and an auto-precharge flag. It is meant for a protocol monitor, a memory model front end or a controller self-check.

The decoder compares the clock enable sampled on the previous edge with the one sampled now. This lets it separate power-down and self-refresh entry and exit from ordinary commands. It keeps its own record of which banks hold an open row. It also runs a short lockout window after every mode-register write. Any rule break raises a one-cycle illegal-command pulse, aligned with the decoded command that caused it.

Top module: `ddr_cmd_decoder`

## Requirements
- R1: While reset is held, and until the first command after reset, the outputs show NOP only: cmdOneHot = 1 (bit 0), bankOneHot = 0, allBanks = 0, autoPre = 0, illegalCmd = 0. Reset treats the previous clock enable as high.
- R2: With clock enable high on both the previous and the current edge, a high chip select masks the pins, and the decoder reports NOP whatever the strobe lines carry.
- R3: The one-hot bit positions are NOP 0, MRS 1, EMRS 2, REF 3, SR-entry 4, SR-exit 5, PD-entry 6, PD-exit 7, ACT 8, RD 9, WR 10, BST 11, PRE 12. The strobe code {rasN,casN,weN} decodes as follows: 000 is MRS, or EMRS when bankAddr[0] is 1; 001 is REF; 011 is ACT; 101 is RD; 100 is WR; 110 is BST; 010 is PRE; 111 is NOP. Exactly one bit is set in every cycle.
- R4: For ACT, RD, WR and single-bank PRE, bankOneHot bit k marks bank letter k, with A=0, B=1, C=2, D=3. bankAddr 00 gives A, 10 gives B, 01 gives C and 11 gives D. Any other command gives bankOneHot = 0.
- R5: PRE with A10 high gives bankOneHot = 1111 and allBanks = 1, whatever bankAddr is.
- R6: autoPre is 1 exactly for RD or WR issued with A10 high.
- R7: A fall of clock enable with chip select low and code 001 is SR-entry. The next rise of clock enable is SR-exit.
- R8: Any other fall of clock enable is PD-entry, even with chip select high. A rise of clock enable outside self refresh is PD-exit. Clock enable low on both edges gives NOP.
- R9: MRS or EMRS issued while any bank is open raises illegalCmd.
- R10: REF or SR-entry issued while any bank is open raises illegalCmd.
- R11: A command other than NOP in the cycle right after MRS or EMRS raises illegalCmd. A command two cycles after is legal.
- R12: ACT opens its bank. PRE closes its bank, or every bank when all banks are selected. RD or WR with auto-precharge closes its bank after AP_DELAY further edges (default 4), so a REF on the 4th edge after the read is illegal and a REF on the 5th is legal.
- R13: All outputs are registered and change on the edge after the one that sampled the pins. illegalCmd lasts one cycle per offending command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Active-low synchronous reset |
| csN | input | 1 | Chip select, active low |
| rasN | input | 1 | Row strobe, active low |
| casN | input | 1 | Column strobe, active low |
| weN | input | 1 | Write enable, active low |
| cke | input | 1 | Clock enable |
| apBit | input | 1 | A10: all-banks for PRE, auto-precharge for RD/WR |
| bankAddr | input | 2 | Bank address, bit 1 = BA1, bit 0 = BA0 |
| cmdOneHot | output | 13 | Decoded command, one-hot (R3 positions) |
| bankOneHot | output | 4 | Addressed bank in letter order A..D |
| allBanks | output | 1 | Precharge of all banks |
| autoPre | output | 1 | Read/write with auto-precharge |
| illegalCmd | output | 1 | One-cycle rule-violation pulse |

## Verification
The assertions assume that the pins are stable around each rising edge and that clock enable is never left undriven. They also assume a self-refresh exit only ever follows an entry, which the decoder's own state guarantees. The stimulus drives every pin on the falling edge and holds clock enable high during reset, so the first edge after reset has a defined history. The sequence reaches the lockout, the open-bank and the auto-precharge windows at their exact edges, one cycle inside and one cycle outside, so every violation is seen at its boundary.

// File: rtl/ddr_cmd_pkg.sv
package ddr_cmd_pkg;
  localparam int NCMD  = 13;
  localparam int NBANK = 4;

  typedef enum logic [3:0] {
    C_NOP  = 4'd0,
    C_MRS  = 4'd1,
    C_EMRS = 4'd2,
    C_REF  = 4'd3,
    C_SRE  = 4'd4,
    C_SRX  = 4'd5,
    C_PDE  = 4'd6,
    C_PDX  = 4'd7,
    C_ACT  = 4'd8,
    C_RD   = 4'd9,
    C_WR   = 4'd10,
    C_BST  = 4'd11,
    C_PRE  = 4'd12
  } cmd_e;

  typedef struct packed {
    logic srActive;
    logic illegal;
  } ctrl_strobe_t;
endpackage

// File: rtl/ddr_cmd_control.sv
module ddr_cmd_control
  import ddr_cmd_pkg::*;
#(
  parameter int LOCK_CYCLES = 2,
  parameter int AP_DELAY    = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  cmd_e                     cmdNow,
  input  logic [$clog2(NBANK)-1:0] bankIdx,
  input  logic                     allSel,
  input  logic                     apReq,
  output ctrl_strobe_t             strobes
);
  localparam int LW = $clog2(LOCK_CYCLES + 1);
  localparam int AW = $clog2(AP_DELAY + 1);

  logic [LW-1:0]    lockCnt;
  logic [NBANK-1:0] openBanks;
  logic             srActive;
  logic             isMrs, isRefLike, lockHit, bankHit;

  assign isMrs     = (cmdNow == C_MRS) || (cmdNow == C_EMRS);
  assign isRefLike = (cmdNow == C_REF) || (cmdNow == C_SRE);
  assign bankHit   = |openBanks;
  assign lockHit   = (lockCnt != '0) && (cmdNow != C_NOP);

  assign strobes.srActive = srActive;
  assign strobes.illegal  = ((isMrs || isRefLike) && bankHit) || lockHit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lockCnt  <= '0;
      srActive <= 1'b0;
    end else begin
      if (isMrs)               lockCnt <= LW'(LOCK_CYCLES - 1);
      else if (lockCnt != '0)  lockCnt <= lockCnt - 1'b1;
      if (cmdNow == C_SRE)      srActive <= 1'b1;
      else if (cmdNow == C_SRX) srActive <= 1'b0;
    end
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic [AW-1:0] apCnt;
    logic          sel, openNext;
    assign sel = (bankIdx == b[$clog2(NBANK)-1:0]);

    always_comb begin
      openNext = openBanks[b];
      if (apCnt == AW'(1))                          openNext = 1'b0;
      if (cmdNow == C_PRE && (allSel || sel))       openNext = 1'b0;
      if (cmdNow == C_ACT && sel)                   openNext = 1'b1;
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        apCnt        <= '0;
        openBanks[b] <= 1'b0;
      end else begin
        openBanks[b] <= openNext;
        if ((cmdNow == C_RD || cmdNow == C_WR) && apReq && sel)
          apCnt <= AW'(AP_DELAY);
        else if (apCnt != '0)
          apCnt <= apCnt - 1'b1;
      end
    end
  end

  a_r7_sr_entry_sets_state: assert property (@(posedge clk) disable iff (!rstN)
    (cmdNow == C_SRE) |=> srActive);

  a_r12_act_opens_bank: assert property (@(posedge clk) disable iff (!rstN)
    (cmdNow == C_ACT) |=> openBanks[$past(bankIdx)]);

  a_r11_lock_after_mrs: assert property (@(posedge clk) disable iff (!rstN)
    isMrs |=> (lockCnt != '0) || (LOCK_CYCLES < 2));
endmodule

// File: rtl/ddr_cmd_datapath.sv
module ddr_cmd_datapath
  import ddr_cmd_pkg::*;
#(
  parameter int LOCK_CYCLES = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     csN,
  input  logic                     rasN,
  input  logic                     casN,
  input  logic                     weN,
  input  logic                     cke,
  input  logic                     apBit,
  input  logic [1:0]               bankAddr,
  input  ctrl_strobe_t             strobes,
  output cmd_e                     cmdNow,
  output logic [$clog2(NBANK)-1:0] bankIdx,
  output logic                     allSel,
  output logic                     apReq,
  output logic [NCMD-1:0]          cmdOneHot,
  output logic [NBANK-1:0]         bankOneHot,
  output logic                     allBanks,
  output logic                     autoPre,
  output logic                     illegalCmd
);
  logic       ckePrev;
  logic [2:0] code;
  logic       usesBank;

  assign code    = {rasN, casN, weN};
  assign bankIdx = {bankAddr[0], bankAddr[1]};

  always_comb begin
    cmdNow = C_NOP;
    if (ckePrev && !cke)
      cmdNow = (!csN && code == 3'b001) ? C_SRE : C_PDE;
    else if (!ckePrev && cke)
      cmdNow = strobes.srActive ? C_SRX : C_PDX;
    else if (ckePrev && cke && !csN) begin
      unique case (code)
        3'b000:  cmdNow = bankAddr[0] ? C_EMRS : C_MRS;
        3'b001:  cmdNow = C_REF;
        3'b011:  cmdNow = C_ACT;
        3'b101:  cmdNow = C_RD;
        3'b100:  cmdNow = C_WR;
        3'b110:  cmdNow = C_BST;
        3'b010:  cmdNow = C_PRE;
        default: cmdNow = C_NOP;
      endcase
    end
  end

  assign allSel   = (cmdNow == C_PRE) && apBit;
  assign apReq    = ((cmdNow == C_RD) || (cmdNow == C_WR)) && apBit;
  assign usesBank = (cmdNow == C_ACT) || (cmdNow == C_RD) ||
                    (cmdNow == C_WR)  || (cmdNow == C_PRE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ckePrev    <= 1'b1;
      cmdOneHot  <= NCMD'(1);
      bankOneHot <= '0;
      allBanks   <= 1'b0;
      autoPre    <= 1'b0;
      illegalCmd <= 1'b0;
    end else begin
      ckePrev    <= cke;
      cmdOneHot  <= NCMD'(1) << cmdNow;
      bankOneHot <= allSel ? '1 : (usesBank ? NBANK'(1) << bankIdx : '0);
      allBanks   <= allSel;
      autoPre    <= apReq;
      illegalCmd <= strobes.illegal;
    end
  end

  a_r3_single_command: assert property (@(posedge clk) disable iff (!rstN)
    $countones(cmdOneHot) == 1);

  a_r5_all_banks_is_precharge: assert property (@(posedge clk) disable iff (!rstN)
    allBanks |-> (cmdOneHot[C_PRE] && bankOneHot == '1));

  a_r6_autopre_rd_wr_only: assert property (@(posedge clk) disable iff (!rstN)
    autoPre |-> (cmdOneHot[C_RD] || cmdOneHot[C_WR]));

  if (LOCK_CYCLES >= 2) begin : g_lockchk
    a_r11_lockout_flagged: assert property (@(posedge clk) disable iff (!rstN)
      ($past(cmdOneHot[C_MRS] || cmdOneHot[C_EMRS]) && !cmdOneHot[C_NOP]) |-> illegalCmd);
  end
endmodule

// File: rtl/ddr_cmd_decoder.sv
module ddr_cmd_decoder
  import ddr_cmd_pkg::*;
#(
  parameter int LOCK_CYCLES = 2,
  parameter int AP_DELAY    = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        csN,
  input  logic        rasN,
  input  logic        casN,
  input  logic        weN,
  input  logic        cke,
  input  logic        apBit,
  input  logic [1:0]  bankAddr,
  output logic [12:0] cmdOneHot,
  output logic [3:0]  bankOneHot,
  output logic        allBanks,
  output logic        autoPre,
  output logic        illegalCmd
);
  ctrl_strobe_t             strobes;
  cmd_e                     cmdNow;
  logic [$clog2(NBANK)-1:0] bankIdx;
  logic                     allSel, apReq;

  ddr_cmd_datapath #(.LOCK_CYCLES(LOCK_CYCLES)) u_dp (
    .clk(clk), .rstN(rstN), .csN(csN), .rasN(rasN), .casN(casN), .weN(weN),
    .cke(cke), .apBit(apBit), .bankAddr(bankAddr), .strobes(strobes),
    .cmdNow(cmdNow), .bankIdx(bankIdx), .allSel(allSel), .apReq(apReq),
    .cmdOneHot(cmdOneHot), .bankOneHot(bankOneHot), .allBanks(allBanks),
    .autoPre(autoPre), .illegalCmd(illegalCmd)
  );

  ddr_cmd_control #(.LOCK_CYCLES(LOCK_CYCLES), .AP_DELAY(AP_DELAY)) u_ctl (
    .clk(clk), .rstN(rstN), .cmdNow(cmdNow), .bankIdx(bankIdx),
    .allSel(allSel), .apReq(apReq), .strobes(strobes)
  );
endmodule

// File: tb/ddr_cmd_decoder_tb.sv
module ddr_cmd_decoder_tb;
  localparam int B_NOP = 0, B_MRS = 1, B_EMRS = 2, B_REF = 3, B_SRE = 4, B_SRX = 5,
                 B_PDE = 6, B_PDX = 7, B_ACT = 8, B_RD = 9, B_WR = 10, B_BST = 11, B_PRE = 12;

  logic clk = 0, rstN = 0, csN = 1, rasN = 1, casN = 1, weN = 1, cke = 1, apBit = 0;
  logic [1:0]  bankAddr = 0;
  logic [12:0] cmdOneHot;
  logic [3:0]  bankOneHot;
  logic        allBanks, autoPre, illegalCmd;

  int checks = 0, failures = 0, cyc = 0;

  typedef struct {
    int          due;
    logic [12:0] cmd;
    logic [3:0]  banks;
    logic        all, ap, ill;
    string       tag;
  } exp_t;
  exp_t q[$];

  ddr_cmd_decoder u_dut (
    .clk(clk), .rstN(rstN), .csN(csN), .rasN(rasN), .casN(casN), .weN(weN),
    .cke(cke), .apBit(apBit), .bankAddr(bankAddr), .cmdOneHot(cmdOneHot),
    .bankOneHot(bankOneHot), .allBanks(allBanks), .autoPre(autoPre),
    .illegalCmd(illegalCmd)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic issue(input logic cs, input logic [2:0] code, input logic ck,
                       input logic a10, input logic [1:0] ba, input int bit_,
                       input logic [3:0] bk, input logic all, input logic ap,
                       input logic ill, input string tag);
    exp_t e;
    @(negedge clk);
    csN = cs; {rasN, casN, weN} = code; cke = ck; apBit = a10; bankAddr = ba;
    e.due = cyc + 1; e.cmd = 13'd1 << bit_; e.banks = bk; e.all = all;
    e.ap = ap; e.ill = ill; e.tag = tag;
    q.push_back(e);
  endtask

  always @(negedge clk) begin
    if (q.size() != 0 && q[0].due == cyc) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (cmdOneHot !== e.cmd || bankOneHot !== e.banks || allBanks !== e.all ||
          autoPre !== e.ap || illegalCmd !== e.ill) begin
        failures++;
        $display("FAIL %s: got cmd=%h bk=%b all=%b ap=%b ill=%b exp cmd=%h bk=%b all=%b ap=%b ill=%b",
                 e.tag, cmdOneHot, bankOneHot, allBanks, autoPre, illegalCmd,
                 e.cmd, e.banks, e.all, e.ap, e.ill);
      end
    end
  end

  initial begin
    fork
      begin
        repeat (4) @(negedge clk);
        checks++;  // R1 reset state
        if (cmdOneHot !== 13'd1 || bankOneHot !== 0 || allBanks || autoPre || illegalCmd) begin
          failures++;
          $display("FAIL R1: got cmd=%h bk=%b ill=%b exp cmd=0001 bk=0000 ill=0",
                   cmdOneHot, bankOneHot, illegalCmd);
        end
        rstN = 1;
        // cs, code, cke, a10, ba, bit, banks, all, ap, ill
        issue(1, 3'b000, 1, 0, 2'b00, B_NOP, 0, 0, 0, 0, "R2 deselect masks MRS");
        issue(0, 3'b111, 1, 0, 2'b00, B_NOP, 0, 0, 0, 0, "R3 nop");
        issue(0, 3'b000, 1, 0, 2'b00, B_MRS, 0, 0, 0, 0, "R3 mrs");
        issue(0, 3'b110, 1, 0, 2'b00, B_BST, 0, 0, 0, 1, "R11 bst in lockout");
        issue(0, 3'b111, 1, 0, 2'b00, B_NOP, 0, 0, 0, 0, "R3 nop");
        issue(0, 3'b000, 1, 0, 2'b01, B_EMRS, 0, 0, 0, 0, "R3 emrs");
        issue(0, 3'b111, 1, 0, 2'b00, B_NOP, 0, 0, 0, 0, "R11 nop in lockout");
        issue(0, 3'b001, 1, 0, 2'b00, B_REF, 0, 0, 0, 0, "R11 ref two after");
        issue(0, 3'b011, 1, 0, 2'b00, B_ACT, 4'b0001, 0, 0, 0, "R4 act A");
        issue(0, 3'b011, 1, 0, 2'b01, B_ACT, 4'b0100, 0, 0, 0, "R4 act C");
        issue(0, 3'b011, 1, 0, 2'b10, B_ACT, 4'b0010, 0, 0, 0, "R4 act B");
        issue(0, 3'b011, 1, 0, 2'b11, B_ACT, 4'b1000, 0, 0, 0, "R4 act D");
        issue(0, 3'b000, 1, 0, 2'b00, B_MRS, 0, 0, 0, 1, "R9 mrs open bank");
        issue(0, 3'b111, 1, 0, 2'b00, B_NOP, 0, 0, 0, 0, "R3 nop");
        issue(0, 3'b001, 1, 0, 2'b00, B_REF, 0, 0, 0, 1, "R10 ref open bank");
        issue(0, 3'b010, 1, 0, 2'b01, B_PRE, 4'b0100, 0, 0, 0, "R4 pre C");
        issue(0, 3'b010, 1, 1, 2'b10, B_PRE, 4'b1111, 1, 0, 0, "R5 pre all");
        issue(0, 3'b001, 1, 0, 2'b00, B_REF, 0, 0, 0, 0, "R12 ref after pre all");
        issue(0, 3'b011, 1, 0, 2'b00, B_ACT, 4'b0001, 0, 0, 0, "R12 act A");
        issue(0, 3'b101, 1, 1, 2'b00, B_RD, 4'b0001, 0, 1, 0, "R6 rd autopre");
        issue(0, 3'b100, 1, 0, 2'b00, B_WR, 4'b0001, 0, 0, 0, "R6 wr no autopre");
        issue(0, 3'b111, 1, 0, 2'b00, B_NOP, 0, 0, 0, 0, "R12 nop");
        issue(0, 3'b111, 1, 0, 2'b00, B_NOP, 0, 0, 0, 0, "R12 nop");
        issue(0, 3'b001, 1, 0, 2'b00, B_REF, 0, 0, 0, 1, "R12 ref before ap done");
        issue(0, 3'b001, 1, 0, 2'b00, B_REF, 0, 0, 0, 0, "R12 ref after ap done");
        issue(0, 3'b001, 0, 0, 2'b00, B_SRE, 0, 0, 0, 0, "R7 sr entry");
        issue(0, 3'b111, 0, 0, 2'b00, B_NOP, 0, 0, 0, 0, "R8 cke low held");
        issue(0, 3'b111, 1, 0, 2'b00, B_SRX, 0, 0, 0, 0, "R7 sr exit");
        issue(0, 3'b111, 1, 0, 2'b00, B_NOP, 0, 0, 0, 0, "R3 nop");
        issue(0, 3'b111, 0, 0, 2'b00, B_PDE, 0, 0, 0, 0, "R8 pd entry");
        issue(0, 3'b111, 0, 0, 2'b00, B_NOP, 0, 0, 0, 0, "R8 cke low held");
        issue(0, 3'b111, 1, 0, 2'b00, B_PDX, 0, 0, 0, 0, "R8 pd exit");
        issue(1, 3'b001, 0, 0, 2'b00, B_PDE, 0, 0, 0, 0, "R8 pd entry cs high");
        issue(0, 3'b111, 1, 0, 2'b00, B_PDX, 0, 0, 0, 0, "R8 pd exit");
        issue(0, 3'b011, 1, 0, 2'b11, B_ACT, 4'b1000, 0, 0, 0, "R4 act D");
        issue(0, 3'b001, 0, 0, 2'b00, B_SRE, 0, 0, 0, 1, "R10 sr entry open bank");
        issue(0, 3'b111, 1, 0, 2'b00, B_SRX, 0, 0, 0, 0, "R7 sr exit");
        issue(0, 3'b010, 1, 1, 2'b01, B_PRE, 4'b1111, 1, 0, 0, "R5 pre all");
        issue(0, 3'b001, 1, 0, 2'b00, B_REF, 0, 0, 0, 0, "R13 ref legal");
        issue(1, 3'b111, 1, 0, 2'b00, B_NOP, 0, 0, 0, 0, "R13 illegal cleared");
        repeat (3) @(negedge clk);
        checks++;
        if (q.size() != 0) begin
          failures++;
          $display("FAIL R13: got %0d pending results exp 0", q.size());
        end
      end
      begin
        repeat (5000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog: got timeout exp completion");
      end
    join_any
    disable fork;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule